// File: doc/BRIEF.md
# Retirement Counter Compare Timer

This block measures time in retired instructions. A count register grows by the number of instructions the core retires in each cycle, from zero to four. A compare register holds a threshold. When the count reaches or steps past the threshold, the block raises a timer-interrupt pending flag. The status and trap logic picks up that flag as one bit of its interrupt-pending field. A separate 64-bit counter also accumulates retirements. Register writes never change it.

Software reads and writes the count and the threshold through a small register port. A write to the threshold doubles as the acknowledge: it loads the new value and drops the pending flag. A dedicated clear input drops the flag as well. The crossing test uses a sum one bit wider than the count. A step that carries the count past the top of its range can therefore still trigger.

Top module: `retire_timer`

## Requirements
- R1: While reset is active and in the first cycle after it, the count, threshold, pending flag and 64-bit total all read zero.
- R2: With no count write, the count becomes the old count plus `retire_cnt` on each rising edge, modulo 2^32.
- R3: The pending flag is set on the edge after a cycle in which the old count is below the threshold and the old count plus `retire_cnt` is at or above it. This covers a step over the threshold as well as a step onto it.
- R4: The crossing sum is computed without wraparound. With count 0xFFFFFFFD, threshold 0xFFFFFFFF and an increment of 4, the flag sets and the count wraps to 1.
- R5: A count write (`wr_en`=1, `wr_sel`=0) loads `wr_data`. The same-cycle increment is discarded, and no crossing check is made that cycle.
- R6: A threshold write (`wr_en`=1, `wr_sel`=1) loads `wr_data` and clears the pending flag. The clear wins over a crossing detected in the same cycle.
- R7: Once set, the pending flag stays set until a threshold write or a cycle with `clr_pend`=1. `clr_pend` wins over a same-cycle crossing.
- R8: The 64-bit total adds `retire_cnt` on every edge and is not affected by any register write.
- R9: `rd_data` shows the count when `rd_sel`=0 and the threshold when `rd_sel`=1, in the same cycle.
- R10: No crossing is reported when the old count is already at or above the threshold, or when the increment is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_cnt | input | 3 | Instructions retired this cycle (0..4) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 threshold |
| wr_data | input | 32 | Write value |
| clr_pend | input | 1 | Clear the pending flag |
| rd_sel | input | 1 | Read target: 0 count, 1 threshold |
| rd_data | output | 32 | Read value |
| timer_pend | output | 1 | Timer-interrupt pending flag |
| cycle_total | output | 64 | Free-running retirement total |

## Verification
A count that drifts from the expected sum shows on `rd_data` on the edge after the bad step. A wrong crossing decision shows on `timer_pend` on the same edge. Because the flag is sticky, a spurious set stays visible until the next acknowledge. A lost set stays missing because the count has already moved past the threshold. The stimulus concentrates on the edges of the crossing test: exact landing, stepping over, wrap at the top of the range, and same-cycle collisions of writes with increments.

// File: rtl/rt_pkg.sv
package rt_pkg;
   typedef enum logic {
      SEL_COUNT   = 1'b0,
      SEL_COMPARE = 1'b1
   } rt_sel_e;
endpackage

// File: rtl/rt_count.sv
module rt_count #(
   parameter int CNT_W = 32,
   parameter int INC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] thr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             hit
);
   localparam int SUM_W = CNT_W + 1;

   logic [SUM_W-1:0] wide_sum;

   assign wide_sum = {1'b0, cnt_q} + {{(SUM_W-INC_W){1'b0}}, inc};
   assign hit      = !ld && (cnt_q < thr) && (wide_sum >= {1'b0, thr});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q <= '0;
      else if (ld) cnt_q <= ld_val;
      else         cnt_q <= wide_sum[CNT_W-1:0];
   end

   // R2: count advances by the increment when not loaded
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(ld) |-> cnt_q == CNT_W'($past(cnt_q) + CNT_W'($past(inc))));
   // R5: a load overrides the increment
   a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(ld) |-> cnt_q == $past(ld_val));
endmodule

// File: rtl/rt_alarm.sv
module rt_alarm #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thr_wr,
   input  logic [CNT_W-1:0] thr_val,
   input  logic             clr,
   input  logic             hit,
   output logic [CNT_W-1:0] thr_q,
   output logic             pend_q
);
   logic drop;

   assign drop = thr_wr || clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      thr_q <= '0;
      else if (thr_wr) thr_q <= thr_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend_q <= 1'b0;
      else if (drop) pend_q <= 1'b0;
      else if (hit)  pend_q <= 1'b1;
   end

   // R3: a detected crossing sets the flag unless dropped
   a_r3_fire: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(hit) && !$past(drop) |-> pend_q);
   // R6: a threshold write clears the flag
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(thr_wr) |-> !pend_q);
   // R7: flag is sticky without a clear
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !drop |=> pend_q);
endmodule

// File: rtl/rt_cycle.sv
module rt_cycle #(
   parameter int CYC_W = 64,
   parameter int INC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc,
   output logic [CYC_W-1:0] total_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) total_q <= '0;
      else        total_q <= total_q + {{(CYC_W-INC_W){1'b0}}, inc};
   end

   // R8: total tracks retirements only
   a_r8_total_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> total_q == CYC_W'($past(total_q) + CYC_W'($past(inc))));
endmodule

// File: rtl/retire_timer.sv
module retire_timer #(
   parameter int CNT_W   = 32,
   parameter int CYC_W   = 64,
   parameter int INC_W   = 3,
   parameter int MAX_INC = 4,
   parameter bit RD_FLOP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] retire_cnt,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             clr_pend,
   input  logic             rd_sel,
   output logic [CNT_W-1:0] rd_data,
   output logic             timer_pend,
   output logic [CYC_W-1:0] cycle_total
);
   import rt_pkg::*;

   if (MAX_INC >= (1 << INC_W)) begin : g_bad_inc
      $error("MAX_INC does not fit in INC_W bits");
   end
   if (CYC_W < CNT_W) begin : g_bad_cyc
      $error("CYC_W must be at least CNT_W");
   end

   rt_sel_e          wsel, rsel;
   logic             cnt_ld, thr_wr, hit;
   logic [CNT_W-1:0] cnt_q, thr_q, rd_mux;

   assign wsel   = rt_sel_e'(wr_sel);
   assign rsel   = rt_sel_e'(rd_sel);
   assign cnt_ld = wr_en && (wsel == SEL_COUNT);
   assign thr_wr = wr_en && (wsel == SEL_COMPARE);

   rt_count #(.CNT_W(CNT_W), .INC_W(INC_W)) u_count (
      .clk(clk), .rst_n(rst_n), .inc(retire_cnt), .ld(cnt_ld),
      .ld_val(wr_data), .thr(thr_q), .cnt_q(cnt_q), .hit(hit));

   rt_alarm #(.CNT_W(CNT_W)) u_alarm (
      .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_val(wr_data),
      .clr(clr_pend), .hit(hit), .thr_q(thr_q), .pend_q(timer_pend));

   rt_cycle #(.CYC_W(CYC_W), .INC_W(INC_W)) u_cycle (
      .clk(clk), .rst_n(rst_n), .inc(retire_cnt), .total_q(cycle_total));

   assign rd_mux = (rsel == SEL_COMPARE) ? thr_q : cnt_q;

   if (RD_FLOP) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_mux;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_mux;
   end

   // R10: no flag rise when count already at or past the threshold
   a_r10_no_false_fire: assert property (@(posedge clk) disable iff (!rst_n)
      !timer_pend && (cnt_q >= thr_q) |=> !timer_pend);
endmodule

// File: tb/retire_timer_bench.sv
module retire_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  retire_cnt = '0;
   logic        wr_en = 1'b0, wr_sel = 1'b0, clr_pend = 1'b0, rd_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        timer_pend;
   logic [63:0] cycle_total;

   typedef struct {
      logic [31:0] cnt;
      logic [31:0] thr;
      logic        pend;
      logic [63:0] tot;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          total = 0, bad = 0;
   logic [31:0] m_cnt = '0, m_thr = '0;
   logic        m_pend = 1'b0;
   logic [63:0] m_tot = '0;
   bit          done = 0;

   always #5 clk = ~clk;

   retire_timer u_retire_timer (
      .clk(clk), .rst_n(rst_n), .retire_cnt(retire_cnt), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .clr_pend(clr_pend),
      .rd_sel(rd_sel), .rd_data(rd_data), .timer_pend(timer_pend),
      .cycle_total(cycle_total));

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] inc, input bit wc, input bit wt,
                       input logic [31:0] d, input bit clr, input string tag);
      logic  hit;
      exp_t  e;
      @(negedge clk);
      retire_cnt = inc; wr_en = wc || wt; wr_sel = wt; wr_data = d; clr_pend = clr;
      hit = !wc && (m_cnt < m_thr) && (({1'b0, m_cnt} + {30'd0, inc}) >= {1'b0, m_thr});
      m_tot = m_tot + {61'd0, inc};
      m_cnt = wc ? d : m_cnt + {29'd0, inc};
      if (wt) m_thr = d;
      m_pend = (wt || clr) ? 1'b0 : (hit ? 1'b1 : m_pend);
      e.cnt = m_cnt; e.thr = m_thr; e.pend = m_pend; e.tot = m_tot; e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            rd_sel = 1'b0; #1;
            chk(e.tag, "count", {32'd0, rd_data}, {32'd0, e.cnt});
            rd_sel = 1'b1; #1;
            chk(e.tag, "threshold", {32'd0, rd_data}, {32'd0, e.thr});
            chk(e.tag, "pend", {63'd0, timer_pend}, {63'd0, e.pend});
            chk(e.tag, "total", cycle_total, e.tot);
         end
      end
   end

   initial begin : watchdog
      #2000000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "pend in reset", {63'd0, timer_pend}, 64'd0);
      rd_sel = 1'b0; #1;
      chk("R1", "count in reset", {32'd0, rd_data}, 64'd0);
      rst_n = 1'b1;
      step(3'd0, 0, 0, 32'd0, 0, "R1");
      step(3'd3, 0, 0, 32'd0, 0, "R2");
      step(3'd4, 0, 0, 32'd0, 0, "R2");
      step(3'd1, 0, 0, 32'd0, 0, "R10");
      // reset count, threshold 10, step over it by 4s
      step(3'd0, 1, 0, 32'd0, 0, "R5");
      step(3'd0, 0, 1, 32'd10, 0, "R6");
      step(3'd4, 0, 0, 32'd0, 0, "R2");
      step(3'd4, 0, 0, 32'd0, 0, "R2");
      step(3'd0, 0, 0, 32'd0, 0, "R10");
      step(3'd4, 0, 0, 32'd0, 0, "R3");
      step(3'd2, 0, 0, 32'd0, 0, "R7");
      step(3'd0, 0, 0, 32'd0, 0, "R7");
      step(3'd1, 0, 0, 32'd0, 1, "R7");
      step(3'd4, 0, 0, 32'd0, 0, "R10");
      // exact landing on threshold
      step(3'd0, 1, 0, 32'd7, 0, "R5");
      step(3'd3, 0, 0, 32'd0, 0, "R3");
      step(3'd0, 0, 1, 32'd20, 0, "R6");
      // count write collides with a would-be crossing
      step(3'd0, 1, 0, 32'd17, 0, "R5");
      step(3'd4, 1, 0, 32'd40, 0, "R5");
      // threshold write collides with a crossing
      step(3'd0, 1, 0, 32'd18, 0, "R5");
      step(3'd4, 0, 1, 32'd50, 0, "R6");
      // clear collides with a crossing
      step(3'd0, 1, 0, 32'd48, 0, "R5");
      step(3'd4, 0, 0, 32'd0, 1, "R7");
      // wrap at the top of the range
      step(3'd0, 1, 0, 32'hFFFF_FFFD, 0, "R4");
      step(3'd0, 0, 1, 32'hFFFF_FFFF, 0, "R9");
      step(3'd4, 0, 0, 32'd0, 0, "R4");
      step(3'd4, 0, 0, 32'd0, 0, "R8");
      step(3'd0, 0, 1, 32'd100, 0, "R8");
      step(3'd2, 0, 0, 32'd0, 0, "R8");
      @(negedge clk);
      retire_cnt = '0; wr_en = 1'b0; clr_pend = 1'b0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule